// File: doc/BRIEF.md
# Grouped Peripheral Event Interrupt Collector

This block gathers single-cycle event pulses from four on-chip sources, namely a waveform generator, a fifth compare unit and the overflows of two timers, and records each in an 8-bit pending register, provided that the source is enabled in a software-loaded 8-bit mask register. Software reads the pending register through a bus read strobe. That read returns the latched events and wipes the register, so a handler copies the value once and tests the copy.

Two sticky summary flags are also produced. The first covers the waveform/compare pair and the second covers the timer-overflow pair. Each flag drives an interrupt request only while its own group enable input is high, and each is cleared by a one-cycle acknowledge pulse. Vectoring and arbitration are left to the surrounding interrupt controller.

Top module: `periph_irq_agg`

## Requirements
- R1: A synchronous active-high reset clears the pending, mask and both summary flags. After reset the read port shows 8'hAA, and no interrupt request is high even with both group enables high.
- R2: Pending and mask bit positions are fixed as follows: compare unit at bit 6, waveform generator at bit 4, timer 2 overflow at bit 2 and timer 1 overflow at bit 0. Bits 7, 5, 3 and 1 always read back as 1.
- R3: A pending bit becomes 1 only when its source pulses in a cycle in which the corresponding mask bit already holds 1. A pulse from a masked source leaves the pending bit and both summary flags unchanged.
- R4: A mask write takes effect from the cycle after the write strobe. An event in the same cycle as the write is judged against the previous mask. Reserved mask bits are not stored.
- R5: The read data port continuously shows the pending value with the reserved bits forced to 1. A read strobe clears every defined pending bit at the clock edge that ends the strobe cycle.
- R6: If a qualified event falls in the same cycle as a clearing read, the event's bit is 1 after that edge.
- R7: The wave summary flag sets when a compare or waveform event is latched. The timer summary flag sets when a timer 1 or timer 2 overflow is latched. Neither flag reacts to the other group.
- R8: A summary flag stays set until its acknowledge pulse. A pending read does not clear it. When an acknowledge coincides with a new latch in the same group, the flag stays set.
- R9: Each interrupt request output is high exactly when its summary flag is set and its group enable input is high. It follows that enable in the same cycle.
- R10: Without a read, pending bits hold their value, and further events on an already pending source leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_wg | input | 1 | Waveform generator event pulse |
| evt_cmp5 | input | 1 | Fifth compare unit event pulse |
| evt_tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| evt_tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wr_data | input | 8 | Mask write data |
| pend_rd_en | input | 1 | Pending register read strobe (clears on read) |
| pend_rd_data | output | 8 | Pending value, reserved bits read as 1 |
| wave_grp_en | input | 1 | Master enable for the wave/compare group |
| tmr_grp_en | input | 1 | Master enable for the timer group |
| wave_ack | input | 1 | One-cycle clear of the wave summary flag |
| tmr_ack | input | 1 | One-cycle clear of the timer summary flag |
| wave_flag | output | 1 | Sticky wave/compare summary flag |
| tmr_flag | output | 1 | Sticky timer-overflow summary flag |
| wave_irq | output | 1 | Wave group interrupt request |
| tmr_irq | output | 1 | Timer group interrupt request |

## Verification
Two pairs of operations can collide in one cycle. The first pair is a clearing read and a new qualified event. The second is a summary acknowledge and a new latch in the same group. The bench drives both pairs on purpose in directed cycles and then at random over a long pseudo-random run. On every clock it compares the read port, both flags and both requests against a behavioural model in which the set always overrides the clear. A mask write that coincides with an event is also driven, and the event must be judged against the old mask.

// File: rtl/pia_pkg.sv
package pia_pkg;

    localparam int REG_W   = 8;
    localparam int BIT_CMP = 6;
    localparam int BIT_WG  = 4;
    localparam int BIT_T2  = 2;
    localparam int BIT_T1  = 0;
    localparam int NUM_GRP = 2;

    localparam logic [REG_W-1:0] DEF_BITS =
        (REG_W'(1) << BIT_CMP) | (REG_W'(1) << BIT_WG) |
        (REG_W'(1) << BIT_T2)  | (REG_W'(1) << BIT_T1);
    localparam logic [REG_W-1:0] RSVD_BITS = ~DEF_BITS;

    localparam logic [REG_W-1:0] WAVE_BITS = (REG_W'(1) << BIT_CMP) | (REG_W'(1) << BIT_WG);
    localparam logic [REG_W-1:0] TMR_BITS  = (REG_W'(1) << BIT_T2)  | (REG_W'(1) << BIT_T1);

    typedef struct packed {
        logic cmp;
        logic wg;
        logic t2;
        logic t1;
    } pia_evt_t;

    function automatic logic [REG_W-1:0] evt_to_vec(input pia_evt_t e);
        logic [REG_W-1:0] v;
        v          = '0;
        v[BIT_CMP] = e.cmp;
        v[BIT_WG]  = e.wg;
        v[BIT_T2]  = e.t2;
        v[BIT_T1]  = e.t1;
        return v;
    endfunction

    function automatic logic [REG_W-1:0] grp_bits(input int g);
        return (g == 0) ? WAVE_BITS : TMR_BITS;
    endfunction

endpackage

// File: rtl/pia_mask_reg.sv
module pia_mask_reg
    import pia_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (wr_en)
            mask_q <= wr_data & DEF_BITS;
    end

    // R4: reserved positions never hold a stored mask bit after a write
    p_mask_rsvd_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((mask_q & RSVD_BITS) == '0));

endmodule

// File: rtl/pia_pend_reg.sv
module pia_pend_reg
    import pia_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_vec,
    input  logic             clr,
    output logic [REG_W-1:0] pend_q
);

    logic [REG_W-1:0] kept;
    logic [REG_W-1:0] pend_d;

    always_comb begin
        kept   = clr ? '0 : pend_q;
        pend_d = (kept | set_vec) & DEF_BITS;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else
            pend_q <= pend_d;
    end

    // R5: a read with no coincident set leaves nothing pending
    p_rd_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (clr && (set_vec == '0)) |=> (pend_q == '0));

    // R6: set overrides the clearing read
    p_evt_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (clr && (set_vec != '0)) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

    // R10: without a read nothing drops
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

endmodule

// File: rtl/pia_grp_flag.sv
module pia_grp_flag
    import pia_pkg::*;
#(
    parameter logic [REG_W-1:0] GRP_MASK = WAVE_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_vec,
    input  logic             ack,
    input  logic             en,
    output logic             flag,
    output logic             irq
);

    logic hit;

    assign hit = |(set_vec & GRP_MASK);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (ack)
            flag <= 1'b0;
    end

    assign irq = flag & en;

    // R8: sticky until acknowledged
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (flag && !ack) |=> flag);

    // R8: acknowledge without a new latch clears
    p_ack_clr_r8: assert property (@(posedge clk) disable iff (rst)
        (ack && !hit) |=> !flag);

    // R8: a new latch beats the acknowledge
    p_set_beats_ack_r8: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag);

endmodule

// File: rtl/periph_irq_agg.sv
module periph_irq_agg
    import pia_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_wg,
    input  logic             evt_cmp5,
    input  logic             evt_tmr1_ovf,
    input  logic             evt_tmr2_ovf,
    input  logic             mask_wr_en,
    input  logic [REG_W-1:0] mask_wr_data,
    input  logic             pend_rd_en,
    output logic [REG_W-1:0] pend_rd_data,
    input  logic             wave_grp_en,
    input  logic             tmr_grp_en,
    input  logic             wave_ack,
    input  logic             tmr_ack,
    output logic             wave_flag,
    output logic             tmr_flag,
    output logic             wave_irq,
    output logic             tmr_irq
);

    pia_evt_t         evt;
    logic [REG_W-1:0] evt_vec;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] pend_q;

    logic [NUM_GRP-1:0] g_en;
    logic [NUM_GRP-1:0] g_ack;
    logic [NUM_GRP-1:0] g_flag;
    logic [NUM_GRP-1:0] g_irq;

    always_comb begin
        evt.cmp = evt_cmp5;
        evt.wg  = evt_wg;
        evt.t2  = evt_tmr2_ovf;
        evt.t1  = evt_tmr1_ovf;
        evt_vec = evt_to_vec(evt);
        set_vec = evt_vec & mask_q;
    end

    pia_mask_reg u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mask_wr_en),
        .wr_data (mask_wr_data),
        .mask_q  (mask_q)
    );

    pia_pend_reg u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr     (pend_rd_en),
        .pend_q  (pend_q)
    );

    assign pend_rd_data = pend_q | RSVD_BITS;

    assign g_en  = {tmr_grp_en, wave_grp_en};
    assign g_ack = {tmr_ack, wave_ack};

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        pia_grp_flag #(.GRP_MASK(grp_bits(g))) u_flag (
            .clk     (clk),
            .rst     (rst),
            .set_vec (set_vec),
            .ack     (g_ack[g]),
            .en      (g_en[g]),
            .flag    (g_flag[g]),
            .irq     (g_irq[g])
        );
    end

    assign wave_flag = g_flag[0];
    assign tmr_flag  = g_flag[1];
    assign wave_irq  = g_irq[0];
    assign tmr_irq   = g_irq[1];

    // R3: a newly set pending bit needs an event and a mask bit one cycle earlier
    p_set_needs_mask_r3: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & ~$past(pend_q) & ~($past(evt_vec) & $past(mask_q))) == '0));

    // R7: wave flag rises only alongside a pending wave-group bit
    p_wave_grp_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(wave_flag) |-> ((pend_q & WAVE_BITS) != '0));

    // R7: timer flag rises only alongside a pending timer-group bit
    p_tmr_grp_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(tmr_flag) |-> ((pend_q & TMR_BITS) != '0));

    // R2: reserved read positions stay high
    p_rsvd_ones_r2: assert property (@(posedge clk) disable iff (rst)
        ((pend_rd_data & RSVD_BITS) == RSVD_BITS));

endmodule

// File: tb/periph_irq_agg_tb_top.sv
module periph_irq_agg_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       evt_wg = 0, evt_cmp5 = 0, evt_tmr1_ovf = 0, evt_tmr2_ovf = 0;
    logic       mask_wr_en = 0;
    logic [7:0] mask_wr_data = 0;
    logic       pend_rd_en = 0;
    logic [7:0] pend_rd_data;
    logic       wave_grp_en = 0, tmr_grp_en = 0, wave_ack = 0, tmr_ack = 0;
    logic       wave_flag, tmr_flag, wave_irq, tmr_irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // reference state
    logic [7:0] m_mask = 0;
    logic [7:0] m_pend = 0;
    logic       m_sw = 0, m_st = 0;
    logic [31:0] lfsr = 32'hACE1_2357;

    always #4 clk = ~clk;

    periph_irq_agg dut_i (
        .clk(clk), .rst(rst),
        .evt_wg(evt_wg), .evt_cmp5(evt_cmp5),
        .evt_tmr1_ovf(evt_tmr1_ovf), .evt_tmr2_ovf(evt_tmr2_ovf),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .pend_rd_en(pend_rd_en), .pend_rd_data(pend_rd_data),
        .wave_grp_en(wave_grp_en), .tmr_grp_en(tmr_grp_en),
        .wave_ack(wave_ack), .tmr_ack(tmr_ack),
        .wave_flag(wave_flag), .tmr_flag(tmr_flag),
        .wave_irq(wave_irq), .tmr_irq(tmr_irq)
    );

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp,
                       input string req, input string tag);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s (%s): actual %h expected %h at %0t", req, what, tag, act, exp, $time);
        end
    endtask

    // ev order: {cmp5, wg, tmr2, tmr1}
    task automatic cyc(input logic [3:0] ev, input logic wr, input logic [7:0] wd,
                       input logic rd, input logic enw, input logic ent,
                       input logic ackw, input logic ackt, input string tag);
        logic [7:0] ev_vec;
        logic [7:0] setv;
        @(negedge clk);
        {evt_cmp5, evt_wg, evt_tmr2_ovf, evt_tmr1_ovf} = ev;
        mask_wr_en = wr; mask_wr_data = wd; pend_rd_en = rd;
        wave_grp_en = enw; tmr_grp_en = ent; wave_ack = ackw; tmr_ack = ackt;
        #1;
        chk("pend_rd_data", pend_rd_data, m_pend | 8'hAA, "R5", tag);
        chk("wave_flag", {7'd0, wave_flag}, {7'd0, m_sw}, "R7", tag);
        chk("tmr_flag",  {7'd0, tmr_flag},  {7'd0, m_st}, "R7", tag);
        chk("wave_irq", {7'd0, wave_irq}, {7'd0, m_sw & enw}, "R9", tag);
        chk("tmr_irq",  {7'd0, tmr_irq},  {7'd0, m_st & ent}, "R9", tag);
        @(posedge clk);
        ev_vec = {1'b0, ev[3], 1'b0, ev[2], 1'b0, ev[1], 1'b0, ev[0]};
        setv   = ev_vec & m_mask;
        m_pend = (rd ? 8'h00 : m_pend) | setv;
        if (wr) m_mask = wd & 8'h55;
        m_sw = (|(setv & 8'h50)) ? 1'b1 : (ackw ? 1'b0 : m_sw);
        m_st = (|(setv & 8'h05)) ? 1'b1 : (ackt ? 1'b0 : m_st);
    endtask

    task automatic idle(input string tag);
        cyc(4'h0, 0, 8'h00, 0, 1, 1, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        wave_grp_en = 1; tmr_grp_en = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, enables high
        chk("pend_rd_data", pend_rd_data, 8'hAA, "R1", "reset");
        chk("flags", {6'd0, tmr_flag, wave_flag}, 8'h00, "R1", "reset");
        chk("irqs",  {6'd0, tmr_irq, wave_irq},   8'h00, "R1", "reset");
        rst = 0;

        // R3: masked sources ignored
        cyc(4'hF, 0, 8'h00, 0, 1, 1, 0, 0, "R3 all masked");
        idle("R3 after masked");
        // R4: event with mask write in same cycle uses old mask
        cyc(4'hF, 1, 8'hFF, 0, 1, 1, 0, 0, "R4 write+event");
        idle("R4 old mask applied");
        // R4: narrow mask to timer 1 only
        cyc(4'h0, 1, 8'h01, 0, 1, 1, 0, 0, "R4 narrow");
        cyc(4'hF, 0, 8'h00, 0, 1, 1, 0, 0, "R3 only t1");
        idle("R3 t1 latched");
        // R10: repeat events, no read
        cyc(4'h1, 0, 8'h00, 0, 1, 1, 0, 0, "R10 repeat");
        idle("R10 hold");
        // R5: read clears
        cyc(4'h0, 0, 8'h00, 1, 1, 1, 0, 0, "R5 read");
        idle("R5 cleared");
        // R2: each source at its position
        cyc(4'h0, 1, 8'hFF, 0, 1, 1, 1, 1, "R2 mask all");
        for (int i = 0; i < 4; i++) begin
            cyc(4'(1 << i), 0, 8'h00, 0, 1, 1, 0, 0, "R2 single");
            cyc(4'h0, 0, 8'h00, 1, 1, 1, 0, 0, "R2 read single");
            cyc(4'h0, 0, 8'h00, 0, 1, 1, 1, 1, "R8 ack");
        end
        // R6: event during clearing read
        cyc(4'h8, 0, 8'h00, 0, 1, 1, 0, 0, "R6 pre");
        cyc(4'h4, 0, 8'h00, 1, 1, 1, 0, 0, "R6 collide");
        idle("R6 wg survives");
        // R8: read leaves flags, ack+latch same cycle keeps flag
        cyc(4'h0, 0, 8'h00, 1, 1, 1, 0, 0, "R8 read keeps flag");
        cyc(4'h8, 0, 8'h00, 0, 1, 1, 1, 0, "R8 ack+set");
        idle("R8 still set");
        // R9: enables gate the requests
        cyc(4'h0, 0, 8'h00, 0, 0, 1, 0, 0, "R9 wave off");
        cyc(4'h2, 0, 8'h00, 0, 0, 0, 0, 0, "R9 t2 set both off");
        cyc(4'h0, 0, 8'h00, 0, 1, 0, 0, 0, "R9 wave on");
        // R7: group separation
        cyc(4'h0, 0, 8'h00, 1, 1, 1, 1, 1, "R7 clean");
        cyc(4'h1, 0, 8'h00, 0, 1, 1, 0, 0, "R7 timer only");
        idle("R7 wave unaffected");
        cyc(4'h0, 0, 8'h00, 0, 1, 1, 0, 1, "R7 ack timer");
        cyc(4'h4, 0, 8'h00, 0, 1, 1, 0, 0, "R7 wave only");
        idle("R7 timer unaffected");

        // pseudo-random run, collisions included
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cyc(lfsr[3:0] & lfsr[7:4], (lfsr[15:12] == 4'h0), lfsr[23:16],
                lfsr[8] & lfsr[9], lfsr[10] | lfsr[11], lfsr[24] | lfsr[25],
                lfsr[26] & lfsr[27], lfsr[28] & lfsr[29], "random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule